// File: doc/BRIEF.md
# Round-Robin Switch Allocator for a Five-Port Wormhole Router

This block decides, on every clock cycle, which input port of a five-port router may drive each output port of the crossbar. Each input presents a five-bit request naming the output it wants. For every output that is currently free and not stalled, the allocator picks one requesting input in round-robin order. That output then stays tied to its winner for the whole wormhole packet, until the winner reports that its last flit has gone.

Each output has a stall-go stop bit from its downstream receiver. While the stop bit is high, the crossbar connection for that output and the grant of its owning input are hidden. The allocation is not lost, and no new allocation is made toward that output. The allocator emits a 25-bit crossbar select vector and a per-input grant vector. The datapath and input buffers sit outside this block.

Top module: `sa_switch_alloc`

## Requirements
- R1: While rst_n is low, every bit of xbar_sel_o and grant_o is 0, and all round-robin pointers restart at input 0.
- R2: Port index 0..4 stands for Local, North, South, West, East. Input i drives req_i[i*5 +: 5], where bit o asks for output o. xbar_sel_o[o*5+i] = 1 means output o carries input i, and grant_o[i] = 1 means input i is connected. A request sampled at a clock edge toward a free, unstalled output shows up on xbar_sel_o after that edge.
- R3: Among several inputs requesting the same free output, the winner is the first requester met when scanning upward (cyclically) from that output's pointer.
- R4: When an output is released, its pointer moves to the input after the released owner, wrapping from 4 to 0.
- R5: Once allocated, an output stays with its owner; competing requests toward it have no effect until release.
- R6: tail_sent_i[i] high at an edge while input i owns output o clears that allocation at the edge. The output reads 0 for at least one cycle and can be re-allocated from the next edge on.
- R7: While stop_i[o] is 1, all five select bits of output o are 0, and the owner's grant bit is 0 unless it holds another output. The lock is kept and reappears when stop_i[o] drops. No new allocation is made toward a stopped output.
- R8: If an input sets several request bits, only the lowest-numbered requested output is considered.
- R9: An input that already owns an output is not considered for any other; each output selects at most one input and each input reaches at most one output.
- R10: tail_sent_i[i] for an input that owns no output has no effect.
- R11: Different outputs are allocated independently and may all be granted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 25 | Per-input output requests, input i at bits i*5+4..i*5 |
| stop_i | input | 5 | Stall-go stop, one bit per output |
| tail_sent_i | input | 5 | Last flit forwarded, one bit per input |
| xbar_sel_o | output | 25 | Crossbar select, bit o*5+i joins input i to output o |
| grant_o | output | 5 | Input currently connected to an output |

## Verification
The main function is tried with a lone request, with three inputs contending for one output from different pointer positions, and with four outputs allocated in one cycle. These patterns separate round-robin from fixed priority and show that outputs do not interfere with one another. Multi-bit requests and requests from inputs that already own an output show whether the one-output-per-input rule comes from request filtering. Stop masks are applied to locked outputs and to a free output with waiting requesters, which separates hiding a lock from blocking a new allocation. Stray tail-sent pulses, a release followed by re-allocation, and a mid-run reset check release handling and pointer recovery.

// File: rtl/sa_pkg.sv
package sa_pkg;

  localparam int unsigned SA_PORTS = 5;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_NORTH = 3'd1,
    PORT_SOUTH = 3'd2,
    PORT_WEST  = 3'd3,
    PORT_EAST  = 3'd4
  } sa_port_e;

endpackage

// File: rtl/sa_req_filter.sv
// Keeps the lowest requested output of each idle input and regroups the
// requests by output.
module sa_req_filter #(
  parameter int unsigned NPORT = sa_pkg::SA_PORTS
) (
  input  logic [NPORT*NPORT-1:0]        req_i,
  input  logic [NPORT-1:0]              idle_i,
  output logic [NPORT-1:0][NPORT-1:0]   cand_o
);

  logic [NPORT-1:0][NPORT-1:0] low_req;

  for (genvar gi = 0; gi < NPORT; gi++) begin : g_in
    logic [NPORT-1:0] raw;
    assign raw        = req_i[gi*NPORT +: NPORT];
    assign low_req[gi] = idle_i[gi] ? (raw & (~raw + NPORT'(1))) : '0;
  end

  for (genvar go = 0; go < NPORT; go++) begin : g_out
    for (genvar gi = 0; gi < NPORT; gi++) begin : g_bit
      assign cand_o[go][gi] = low_req[gi][go];
    end
  end

endmodule

// File: rtl/sa_rr_pick.sv
// Picks the first set candidate, scanning cyclically upward from ptr_i.
module sa_rr_pick #(
  parameter int unsigned NPORT = sa_pkg::SA_PORTS,
  localparam int unsigned IDXW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic [NPORT-1:0] cand_i,
  input  logic [IDXW-1:0]  ptr_i,
  output logic             win_o,
  output logic [IDXW-1:0]  win_idx_o
);

  always_comb begin
    int idx;
    win_o     = 1'b0;
    win_idx_o = '0;
    idx       = 0;
    for (int k = 0; k < int'(NPORT); k++) begin
      idx = int'(ptr_i) + k;
      if (idx >= int'(NPORT)) idx = idx - int'(NPORT);
      if (!win_o && cand_i[idx]) begin
        win_o     = 1'b1;
        win_idx_o = IDXW'(idx);
      end
    end
  end

endmodule

// File: rtl/sa_out_slot.sv
// Per-output allocation state: lock flag, owner and round-robin pointer.
module sa_out_slot #(
  parameter int unsigned NPORT = sa_pkg::SA_PORTS,
  localparam int unsigned IDXW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] cand_i,
  input  logic             stop_i,
  input  logic [NPORT-1:0] tail_sent_i,
  output logic             busy_o,
  output logic [IDXW-1:0]  owner_o
);

  logic            busy_q, busy_d;
  logic [IDXW-1:0] owner_q, owner_d;
  logic [IDXW-1:0] ptr_q, ptr_d;
  logic            win;
  logic [IDXW-1:0] win_idx;
  logic            release_now, take_now, state_en;

  sa_rr_pick #(.NPORT(NPORT)) u_pick (
    .cand_i    (cand_i),
    .ptr_i     (ptr_q),
    .win_o     (win),
    .win_idx_o (win_idx)
  );

  assign release_now = busy_q && tail_sent_i[owner_q];
  assign take_now    = !busy_q && !stop_i && win;
  assign state_en    = release_now || take_now;

  always_comb begin
    busy_d  = busy_q;
    owner_d = owner_q;
    ptr_d   = ptr_q;
    if (release_now) begin
      busy_d = 1'b0;
      ptr_d  = (owner_q == IDXW'(NPORT-1)) ? '0 : owner_q + IDXW'(1);
    end else if (take_now) begin
      busy_d  = 1'b1;
      owner_d = win_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
      ptr_q   <= '0;
    end else if (state_en) begin
      busy_q  <= busy_d;
      owner_q <= owner_d;
      ptr_q   <= ptr_d;
    end
  end

  assign busy_o  = busy_q;
  assign owner_o = owner_q;

endmodule

// File: rtl/sa_switch_alloc.sv
module sa_switch_alloc #(
  parameter int unsigned NPORT = sa_pkg::SA_PORTS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORT*NPORT-1:0] req_i,
  input  logic [NPORT-1:0]       stop_i,
  input  logic [NPORT-1:0]       tail_sent_i,
  output logic [NPORT*NPORT-1:0] xbar_sel_o,
  output logic [NPORT-1:0]       grant_o
);

  localparam int unsigned IDXW = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic [NPORT-1:0][NPORT-1:0] cand;
  logic [NPORT-1:0]            idle;
  logic [NPORT-1:0]            busy;
  logic [IDXW-1:0]             owner [NPORT];

  sa_req_filter #(.NPORT(NPORT)) u_filter (
    .req_i  (req_i),
    .idle_i (idle),
    .cand_o (cand)
  );

  for (genvar go = 0; go < NPORT; go++) begin : g_slot
    sa_out_slot #(.NPORT(NPORT)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .cand_i      (cand[go]),
      .stop_i      (stop_i[go]),
      .tail_sent_i (tail_sent_i),
      .busy_o      (busy[go]),
      .owner_o     (owner[go])
    );
  end

  always_comb begin
    idle = '1;
    for (int o = 0; o < int'(NPORT); o++) begin
      for (int i = 0; i < int'(NPORT); i++) begin
        if (busy[o] && owner[o] == IDXW'(i)) idle[i] = 1'b0;
      end
    end
  end

  always_comb begin
    xbar_sel_o = '0;
    grant_o    = '0;
    for (int o = 0; o < int'(NPORT); o++) begin
      for (int i = 0; i < int'(NPORT); i++) begin
        if (busy[o] && !stop_i[o] && owner[o] == IDXW'(i)) begin
          xbar_sel_o[o*NPORT+i] = 1'b1;
          grant_o[i]            = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sa_switch_alloc_chk.sv
module sa_switch_alloc_chk #(
  parameter int unsigned NPORT = sa_pkg::SA_PORTS
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NPORT*NPORT-1:0] req_i,
  input logic [NPORT-1:0]       stop_i,
  input logic [NPORT-1:0]       tail_sent_i,
  input logic [NPORT*NPORT-1:0] xbar_sel_o,
  input logic [NPORT-1:0]       grant_o
);

  for (genvar go = 0; go < NPORT; go++) begin : g_o
    // R9
    one_input_per_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(xbar_sel_o[go*NPORT +: NPORT]));
    // R7
    stopped_output_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i[go] |-> (xbar_sel_o[go*NPORT +: NPORT] == '0));
    for (genvar gi = 0; gi < NPORT; gi++) begin : g_i
      // R5
      lock_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xbar_sel_o[go*NPORT+gi] && !tail_sent_i[gi])
          |=> (stop_i[go] || xbar_sel_o[go*NPORT+gi]));
      // R6
      tail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xbar_sel_o[go*NPORT+gi] && tail_sent_i[gi]) |=> !xbar_sel_o[go*NPORT+gi]);
      // R2
      grant_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(xbar_sel_o[go*NPORT+gi]) && !$past(stop_i[go]))
          |-> $past(req_i[gi*NPORT+go]));
    end
  end

  for (genvar gi = 0; gi < NPORT; gi++) begin : g_col
    logic [NPORT-1:0] col;
    for (genvar go = 0; go < NPORT; go++) begin : g_c
      assign col[go] = xbar_sel_o[go*NPORT+gi];
    end
    // R9
    one_output_per_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));
    // R2
    grant_matches_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o[gi] == (col != '0));
  end

endmodule

bind sa_switch_alloc sa_switch_alloc_chk #(.NPORT(NPORT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .stop_i      (stop_i),
  .tail_sent_i (tail_sent_i),
  .xbar_sel_o  (xbar_sel_o),
  .grant_o     (grant_o)
);

// File: tb/test_sa_switch_alloc.sv
module test_sa_switch_alloc;

  logic        clk;
  logic        rst_n;
  logic [24:0] req;
  logic [4:0]  stop;
  logic [4:0]  tail;
  logic [24:0] sel;
  logic [4:0]  grant;
  int          total;
  int          bad;
  bit          done;

  sa_switch_alloc i_sa_switch_alloc (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req),
    .stop_i      (stop),
    .tail_sent_i (tail),
    .xbar_sel_o  (sel),
    .grant_o     (grant)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [3:0]  tag;
    logic [24:0] req;
    logic [4:0]  stop;
    logic [4:0]  tail;
    logic [24:0] sel;
  } vec_t;

  // req groups: {in4,in3,in2,in1,in0}, group bit o = output o
  // sel groups: {out4,out3,out2,out1,out0}, group bit i = input i
  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    // R2 lone request in1 -> out2
    '{4'd2, {5'b0,5'b0,5'b0,5'b00100,5'b0}, 5'b0, 5'b0, {5'b0,5'b0,5'b00010,5'b0,5'b0}},
    // R5 in3 contends for locked out2; in0 takes out0
    '{4'd5, {5'b0,5'b00100,5'b0,5'b00100,5'b00001}, 5'b0, 5'b0, {5'b0,5'b0,5'b00010,5'b0,5'b00001}},
    // R7 stop hides out2 lock
    '{4'd7, {5'b0,5'b00100,5'b0,5'b00100,5'b00001}, 5'b00100, 5'b0, {5'b0,5'b0,5'b0,5'b0,5'b00001}},
    // R6 in1 tail releases out2
    '{4'd6, {5'b0,5'b00100,5'b0,5'b0,5'b00001}, 5'b0, 5'b00010, {5'b0,5'b0,5'b0,5'b0,5'b00001}},
    // R3 pointer 2: in3 beats in1 and in4
    '{4'd3, {5'b00100,5'b00100,5'b0,5'b00100,5'b00001}, 5'b0, 5'b0, {5'b0,5'b0,5'b01000,5'b0,5'b00001}},
    // R6 in3 releases out2
    '{4'd6, {5'b00100,5'b00100,5'b0,5'b00100,5'b00001}, 5'b0, 5'b01000, {5'b0,5'b0,5'b0,5'b0,5'b00001}},
    // R4 pointer now 4: in4 beats in1
    '{4'd4, {5'b00100,5'b0,5'b0,5'b00100,5'b00001}, 5'b0, 5'b0, {5'b0,5'b0,5'b10000,5'b0,5'b00001}},
    // R10 stray tail from in2, in0 releases out0
    '{4'd10, {5'b00100,5'b0,5'b0,5'b00100,5'b0}, 5'b0, 5'b00101, {5'b0,5'b0,5'b10000,5'b0,5'b0}},
    // R8 in2 asks outputs 1,3,4: gets out1
    '{4'd8, {5'b00100,5'b0,5'b11010,5'b00100,5'b0}, 5'b0, 5'b0, {5'b0,5'b0,5'b10000,5'b00100,5'b0}},
    // R9 in2 owns out1, asks free out3: refused
    '{4'd9, {5'b00100,5'b0,5'b01000,5'b00100,5'b0}, 5'b0, 5'b0, {5'b0,5'b0,5'b10000,5'b00100,5'b0}},
    // R11 out3 and out4 granted together
    '{4'd11, {5'b00100,5'b10000,5'b01000,5'b00100,5'b01000}, 5'b0, 5'b0, {5'b01000,5'b00001,5'b10000,5'b00100,5'b0}},
    // R7 stop on out1,2,4
    '{4'd7, {5'b00100,5'b10000,5'b01000,5'b00100,5'b01000}, 5'b10110, 5'b0, {5'b0,5'b00001,5'b0,5'b0,5'b0}},
    // R6 all tails release all outputs
    '{4'd6, 25'b0, 5'b0, 5'b11111, 25'b0},
    // R7 stop blocks new allocation on free out2
    '{4'd7, {5'b0,5'b0,5'b0,5'b00100,5'b00100}, 5'b00100, 5'b0, 25'b0},
    // R4 pointer wrapped 4 -> 0: in0 beats in1
    '{4'd4, {5'b0,5'b0,5'b0,5'b00100,5'b00100}, 5'b0, 5'b0, {5'b0,5'b0,5'b00001,5'b0,5'b0}}
  };

  function automatic logic [4:0] grant_of(input logic [24:0] s);
    logic [4:0] g;
    g = '0;
    for (int o = 0; o < 5; o++) g = g | s[o*5 +: 5];
    return g;
  endfunction

  task automatic check(input string rq, input logic [24:0] got, input logic [24:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", rq, got, exp);
    end
  endtask

  task automatic step(input logic [24:0] r, input logic [4:0] s, input logic [4:0] t);
    @(negedge clk);
    req  = r;
    stop = s;
    tail = t;
    @(posedge clk);
    #2;
  endtask

  initial begin
    done  = 1'b0;
    total = 0;
    bad   = 0;
    rst_n = 1'b0;
    req   = '0;
    stop  = '0;
    tail  = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check("R1 sel", sel, 25'b0);
    check("R1 grant", 25'(grant), 25'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      step(TBL[v].req, TBL[v].stop, TBL[v].tail);
      check($sformatf("R%0d vec%0d sel", TBL[v].tag, v), sel, TBL[v].sel);
      check($sformatf("R%0d vec%0d grant", TBL[v].tag, v), 25'(grant), 25'(grant_of(TBL[v].sel)));
    end

    // R6 in0 releases out2 with in1 waiting: one dark cycle, then in1
    step({5'b0,5'b0,5'b0,5'b00100,5'b0}, 5'b0, 5'b00001);
    check("R6 gap", sel, 25'b0);
    step({5'b0,5'b0,5'b0,5'b00100,5'b0}, 5'b0, 5'b0);
    check("R6 realloc", sel, {5'b0,5'b0,5'b00010,5'b0,5'b0});
    // pointer of out2 is 1 here; release in1 so pointer becomes 2
    step(25'b0, 5'b0, 5'b00010);
    check("R4 release in1", sel, 25'b0);

    // R1 mid-run reset clears outputs and pointers
    step({5'b0,5'b00100,5'b0,5'b0,5'b00100}, 5'b0, 5'b0);
    check("R3 pointer 2 picks in3", sel, {5'b0,5'b0,5'b01000,5'b0,5'b0});
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", sel, 25'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step({5'b0,5'b00100,5'b0,5'b0,5'b00100}, 5'b0, 5'b0);
    check("R1 pointer back to 0", sel, {5'b0,5'b0,5'b00001,5'b0,5'b0});

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule